// File: doc/BRIEF.md
# Event-Triggered Double-Buffered Pulse Port

This block is a multi-bit output port for generating pulse waveforms. Software places the level for the next step in a staging register ahead of time. The pins change only when a compare-match strobe from an external timer fires. Because the pin update happens in hardware on the timer event, the time between edges equals the timer's compare period. The time software takes to respond does not shift the edges.

A host write port loads the registers:
- the current pin levels,
- the staged next levels,
- a per-bit transfer mask,
- a per-bit drive direction,
- a control word that picks which of several timer strobes is the trigger and enables the interrupt.

On each selected strobe, masked bits copy staged data into the pin register. A sticky event flag is also set, so software can stage the following value in time. A combinational read port returns any register.

Top module: `trig_pulse_port`

## Requirements
- R1: Reset (synchronous, active high) clears every register. After reset, `pin_out` and `pin_oe` are 0, `irq` is 0 and every readback returns 0.
- R2: Register addresses are: 0 pin levels, 1 staged next levels, 2 transfer mask, 3 direction, 4 control, 5 status. Control holds the trigger select in bits [1:0] and the interrupt enable in bit 2. Status holds the event flag in bit 0. A write takes effect at the next clock edge. `rd_data` returns the register at `rd_addr`, and unmapped addresses read 0.
- R3: `pin_oe[i]` is 1 exactly when direction bit i and mask bit i are both 1. When `pin_oe[i]` is 0 the pin is tri-stated, but `pin_out` always shows the internal level register.
- R4: The trigger is `cmp_strobe[sel]`. At the clock edge where it is high, every bit with mask 1 loads its staged value. The new value is visible after that edge.
- R5: On a trigger, bits with mask 0 keep their value. Strobes other than the selected one change nothing.
- R6: If a host write to the pin-level register falls in the same cycle as a trigger, masked bits take the staged value and unmasked bits take the written value.
- R7: A selected strobe sets the event flag whatever the interrupt enable is. `irq` is the flag ANDed with the enable.
- R8: Writing status with bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it unchanged. If a clear and a trigger fall in the same cycle, the flag stays set.
- R9: If a write to the staged register falls in the same cycle as a trigger, the transfer uses the staged value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Read data for `rd_addr` |
| cmp_strobe | input | 4 | One-cycle compare-match strobes from the timer |
| pin_out | output | 8 | Pin level register |
| pin_oe | output | 8 | Per-pin drive enable (0 = high impedance) |
| irq | output | 1 | Event interrupt request |

## Verification
The bench targets three same-cycle collisions:
- A host write to the pin levels during a trigger. A design that lets the host win would lose the staged edge. A design that lets the trigger overwrite every bit would discard the host's unmasked bits.
- A staged-register write during a trigger. Forwarding the new value would make pins jump a step early.
- A flag clear during a trigger. Letting the clear win would drop an event and stall the software refill loop.

The bench also fires unselected strobes and toggles the interrupt enable while the flag is set. A decoder tied to the wrong strobe, or an `irq` that ignores the enable, then shows at the pins.

// File: rtl/trig_pulse_pkg.sv
package trig_pulse_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_LEVEL = 3'd0,
        A_STAGE = 3'd1,
        A_MASK  = 3'd2,
        A_DIR   = 3'd3,
        A_CTRL  = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    function automatic logic hits(input logic en, input logic [ADDR_W-1:0] addr,
                                  input reg_addr_e target);
        return en && (addr == target);
    endfunction

endpackage

// File: rtl/trig_pulse_sel.sv
module trig_pulse_sel #(
    parameter int NUM_TRIG = 4,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_TRIG-1:0] strobe,
    input  logic [SEL_W-1:0]    sel,
    output logic                trig
);
    logic [NUM_TRIG-1:0] hit;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_dec
        assign hit[g] = strobe[g] && (sel == SEL_W'(g));
    end

    assign trig = |hit;
endmodule

// File: rtl/trig_pulse_regs.sv
module trig_pulse_regs
    import trig_pulse_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              trig,
    output logic [WIDTH-1:0]  stage_q,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              irq_en_q,
    output logic              flag_q
);
    logic wr_stage, wr_mask, wr_dir, wr_ctrl, wr_stat;

    assign wr_stage = hits(wr_en, wr_addr, A_STAGE);
    assign wr_mask  = hits(wr_en, wr_addr, A_MASK);
    assign wr_dir   = hits(wr_en, wr_addr, A_DIR);
    assign wr_ctrl  = hits(wr_en, wr_addr, A_CTRL);
    assign wr_stat  = hits(wr_en, wr_addr, A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            mask_q   <= '0;
            dir_q    <= '0;
            sel_q    <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (wr_stage) stage_q <= wr_data;
            if (wr_mask)  mask_q  <= wr_data;
            if (wr_dir)   dir_q   <= wr_data;
            if (wr_ctrl) begin
                sel_q    <= wr_data[SEL_W-1:0];
                irq_en_q <= wr_data[SEL_W];
            end
        end
    end

    // Event flag: set by trigger, cleared by write-one; set wins.
    always_ff @(posedge clk) begin
        if (rst)                      flag_q <= 1'b0;
        else if (trig)                flag_q <= 1'b1;
        else if (wr_stat && wr_data[0]) flag_q <= 1'b0;
    end
endmodule

// File: rtl/trig_pulse_xfer.sv
module trig_pulse_xfer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_ld,
    input  logic [WIDTH-1:0] host_data,
    input  logic             trig,
    input  logic [WIDTH-1:0] stage_q,
    input  logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] level_q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                     level_q[b] <= 1'b0;
            else if (trig && mask_q[b])  level_q[b] <= stage_q[b];
            else if (host_ld)            level_q[b] <= host_data[b];
        end
    end
endmodule

// File: rtl/trig_pulse_port.sv
module trig_pulse_port
    import trig_pulse_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int NUM_TRIG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [WIDTH-1:0]    wr_data,
    input  logic [2:0]          rd_addr,
    output logic [WIDTH-1:0]    rd_data,
    input  logic [NUM_TRIG-1:0] cmp_strobe,
    output logic [WIDTH-1:0]    pin_out,
    output logic [WIDTH-1:0]    pin_oe,
    output logic                irq
);
    localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic [WIDTH-1:0] stage_q, mask_q, dir_q, level_q;
    logic [SEL_W-1:0] sel_q;
    logic             irq_en_q, flag_q, trig;

    trig_pulse_sel #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_sel (
        .strobe (cmp_strobe),
        .sel    (sel_q),
        .trig   (trig)
    );

    trig_pulse_regs #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .trig     (trig),
        .stage_q  (stage_q),
        .mask_q   (mask_q),
        .dir_q    (dir_q),
        .sel_q    (sel_q),
        .irq_en_q (irq_en_q),
        .flag_q   (flag_q)
    );

    trig_pulse_xfer #(.WIDTH(WIDTH)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .host_ld   (hits(wr_en, wr_addr, A_LEVEL)),
        .host_data (wr_data),
        .trig      (trig),
        .stage_q   (stage_q),
        .mask_q    (mask_q),
        .level_q   (level_q)
    );

    assign pin_out = level_q;
    assign pin_oe  = dir_q & mask_q;
    assign irq     = flag_q & irq_en_q;

    always_comb begin
        case (rd_addr)
            A_LEVEL: rd_data = level_q;
            A_STAGE: rd_data = stage_q;
            A_MASK:  rd_data = mask_q;
            A_DIR:   rd_data = dir_q;
            A_CTRL:  rd_data = WIDTH'({irq_en_q, sel_q});
            A_STAT:  rd_data = WIDTH'(flag_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/trig_pulse_chk.sv
module trig_pulse_chk
    import trig_pulse_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic             trig,
    input logic [WIDTH-1:0] stage_q,
    input logic [WIDTH-1:0] mask_q,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic             irq,
    input logic             flag
);
    logic lvl_wr, stat_clr, dir_zero;
    assign lvl_wr   = hits(wr_en, wr_addr, A_LEVEL);
    assign stat_clr = hits(wr_en, wr_addr, A_STAT) && wr_data[0];
    assign dir_zero = hits(wr_en, wr_addr, A_DIR) && (wr_data == '0);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq && !flag));

    a_r3_dir_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dir_zero)) |-> (pin_oe == '0));

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trig)) |->
            (((pin_out ^ $past(stage_q)) & $past(mask_q)) == '0));

    a_r5_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trig) && !$past(lvl_wr)) |->
            (((pin_out ^ $past(pin_out)) & ~$past(mask_q)) == '0));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(trig) && !$past(lvl_wr)) |-> $stable(pin_out));

    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trig)) |-> flag);

    a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stat_clr) && !$past(trig)) |-> !flag);
endmodule

bind trig_pulse_port trig_pulse_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .trig    (trig),
    .stage_q (stage_q),
    .mask_q  (mask_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .flag    (flag_q)
);

// File: tb/sim_trig_pulse_port.sv
module sim_trig_pulse_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] cmp_strobe = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    trig_pulse_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmp_strobe(cmp_strobe),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic       we;
        logic [2:0] addr;
        logic [7:0] wdata;
        logic [3:0] strb;
        logic [7:0] eout;
        logic [7:0] eoe;
        logic       eirq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    // Expected pin levels, drive enables and irq after each clock edge.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 8'h0F, 4'h0, 8'h0F, 8'h00, 1'b0, 4'd2}, // R2 level write
        '{1'b1, 3'd1, 8'hA5, 4'h0, 8'h0F, 8'h00, 1'b0, 4'd2}, // R2 stage write
        '{1'b1, 3'd2, 8'hF0, 4'h0, 8'h0F, 8'h00, 1'b0, 4'd3}, // R3 mask, dir still 0
        '{1'b1, 3'd3, 8'h3C, 4'h0, 8'h0F, 8'h30, 1'b0, 4'd3}, // R3 dir & mask
        '{1'b1, 3'd4, 8'h05, 4'h0, 8'h0F, 8'h30, 1'b0, 4'd2}, // R2 sel=1, irq_en=1
        '{1'b0, 3'd0, 8'h00, 4'h1, 8'h0F, 8'h30, 1'b0, 4'd5}, // R5 unselected strobe
        '{1'b0, 3'd0, 8'h00, 4'h2, 8'hAF, 8'h30, 1'b1, 4'd4}, // R4 transfer, R7 flag
        '{1'b1, 3'd5, 8'h01, 4'h0, 8'hAF, 8'h30, 1'b0, 4'd8}, // R8 clear
        '{1'b1, 3'd1, 8'h5A, 4'h0, 8'hAF, 8'h30, 1'b0, 4'd2}, // new stage
        '{1'b1, 3'd0, 8'h33, 4'h2, 8'h53, 8'h30, 1'b1, 4'd6}, // R6 collision
        '{1'b1, 3'd5, 8'h00, 4'h0, 8'h53, 8'h30, 1'b1, 4'd8}, // R8 write 0 ignored
        '{1'b1, 3'd5, 8'h01, 4'h2, 8'h53, 8'h30, 1'b1, 4'd8}, // R8 set beats clear
        '{1'b1, 3'd4, 8'h01, 4'h0, 8'h53, 8'h30, 1'b0, 4'd7}, // R7 enable off
        '{1'b1, 3'd5, 8'h01, 4'h0, 8'h53, 8'h30, 1'b0, 4'd8}, // R8 clear
        '{1'b1, 3'd1, 8'hFF, 4'h2, 8'h53, 8'h30, 1'b0, 4'd9}, // R9 old stage used
        '{1'b0, 3'd0, 8'h00, 4'h2, 8'hF3, 8'h30, 1'b0, 4'd4}, // R4 new stage now
        '{1'b1, 3'd4, 8'h07, 4'h0, 8'hF3, 8'h30, 1'b1, 4'd7}, // R7 sel=3, en shows flag
        '{1'b1, 3'd2, 8'h0F, 4'h0, 8'hF3, 8'h0C, 1'b1, 4'd3}, // R3 mask change
        '{1'b0, 3'd0, 8'h00, 4'h2, 8'hF3, 8'h0C, 1'b1, 4'd5}, // R5 old strobe ignored
        '{1'b0, 3'd0, 8'h00, 4'h8, 8'hFF, 8'h0C, 1'b1, 4'd4}  // R4 strobe 3
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(req, $sformatf("readback addr %0d", a), rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pin_out", pin_out, 8'h00);
        chk("R1", "pin_oe", pin_oe, 8'h00);
        chk("R1", "irq", {7'd0, irq}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].we;
            wr_addr = VEC[i].addr;
            wr_data = VEC[i].wdata;
            cmp_strobe = VEC[i].strb;
            @(negedge clk);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("row %0d pin_out", i), pin_out, VEC[i].eout);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("row %0d pin_oe", i), pin_oe, VEC[i].eoe);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("row %0d irq", i), {7'd0, irq}, {7'd0, VEC[i].eirq});
        end
        wr_en = 1'b0;
        cmp_strobe = '0;

        // R2 readback of every register and an unmapped address
        rd_chk(3'd0, 8'hFF, "R2");
        rd_chk(3'd1, 8'hFF, "R2");
        rd_chk(3'd2, 8'h0F, "R2");
        rd_chk(3'd3, 8'h3C, "R2");
        rd_chk(3'd4, 8'h07, "R2");
        rd_chk(3'd5, 8'h01, "R2");
        rd_chk(3'd6, 8'h00, "R2");

        // R1 mid-run reset clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "pin_out after reset", pin_out, 8'h00);
        chk("R1", "pin_oe after reset", pin_oe, 8'h00);
        chk("R1", "irq after reset", {7'd0, irq}, 8'h00);
        rd_chk(3'd4, 8'h00, "R1");
        rd_chk(3'd1, 8'h00, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule